// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a high-rate input clock by a programmable ratio N = P*B + A and, alongside it, by a programmable reference ratio R. It does not use one wide counter for N. It models the control side of a dual-modulus prescaler instead. A small prescaler counter runs with modulus P+1 or modulus P. A B counter counts prescaler cycles across a frame. An A counter keeps the prescaler in its P+1 mode for the first A prescaler cycles of each frame. The frame therefore lasts A*(P+1) + (B-A)*P = P*B + A input cycles. This requires A < B. P is a parameter: 16 for an intermediate-frequency loop, or 8 and 6 for the radio and positioning loops.

A frequency-synthesis loop uses the block to drive its phase comparator. The block gives one single-cycle pulse per completed N frame and one per completed R cycle. It also gives a modulus-select output that shows when the prescaler should be dividing by P+1. New B, A and R values arrive with a load strobe. They are range-checked on arrival. Legal values are held pending and take effect only at the next boundary of the divider they belong to. Illegal values raise an error flag and are dropped.

The frame controller has two states. SWALLOW means the prescaler modulus is P+1 and A is still counting. PLAIN means the modulus is P. There are four transitions:
- SWALLOW→PLAIN when the A counter expires.
- PLAIN→PLAIN on a frame end with a new A of zero.
- PLAIN→SWALLOW on a frame end with a new nonzero A.
- Any state stays put while the prescaler is mid-cycle.

After reset the divider runs with defaults B = 229, A = 9 and R = 160.

Top module: `swallow_divider`

## Requirements
- R1: `n_pulse` is high for exactly one input cycle once every P*B + A input cycles of the active configuration (P = 16 by default).
- R2: Within each frame, `mod_hi` is high for the first A*(P+1) input cycles and low for the remaining P*(B-A); it rises only in the cycle after an `n_pulse` and is low whenever `n_pulse` is high.
- R3: `r_pulse` is high for exactly one input cycle once every R input cycles of the active reference ratio.
- R4: While reset is asserted, `n_pulse`, `r_pulse` and `cfg_err` are low and `mod_hi` is high; after release the first `n_pulse` comes at cycle 3673 (B = 229, A = 9) and the first `r_pulse` at cycle 160.
- R5: A load is legal only if B ≥ 1, A ≤ P-1, A < B and R ≥ 2. An illegal load sets `cfg_err` in the cycle after the strobe and changes neither the N nor the R period.
- R6: A legal load clears `cfg_err` in the cycle after the strobe; `cfg_err` changes only after a load strobe.
- R7: A legal B/A load leaves the N frame in progress at its old length, and every later frame uses the new ratio.
- R8: A legal R load leaves the R cycle in progress at its old length, and every later cycle uses the new ratio.
- R9: With A = 0, `mod_hi` stays low for the whole frame; B = 1 with A = 0 gives a frame of exactly P cycles.
- R10: The largest legal ratio, B = 511 with A = 15, gives a frame of 8191 cycles, and R = 511 gives a reference cycle of 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe: capture `cfg_b`, `cfg_a`, `cfg_r` this cycle |
| cfg_b | input | 9 | New B (prescaler cycles per frame) |
| cfg_a | input | 4 | New A (prescaler cycles at modulus P+1), width $clog2(P) |
| cfg_r | input | 9 | New reference ratio R |
| n_pulse | output | 1 | One-cycle pulse at the end of each N frame |
| r_pulse | output | 1 | One-cycle pulse at the end of each R cycle |
| mod_hi | output | 1 | High while the prescaler should divide by P+1 |
| cfg_err | output | 1 | Last load was illegal and was dropped |

## Verification
Some properties are checked on every cycle. Both output pulses are exactly one cycle wide. A frame end never falls inside the swallow phase. The modulus select rises only right after a frame end. The error flag moves only on a load. The gap between frame ends stays bounded. Other behaviour can only be shown by the bench's scenarios: the exact N and R periods for each programmed ratio, the A*(P+1) length of the swallow phase, and the rule that a load leaves the frame in progress at its old length. The scenarios also show that illegal values are dropped while the periods continue unchanged, and they cover the reset defaults and the extreme ratios.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    // Prescaler modulus phase of the current frame.
    typedef enum logic {
        ST_SWALLOW = 1'b0,  // modulus P+1, A counter still running
        ST_PLAIN   = 1'b1   // modulus P for the rest of the frame
    } frame_state_e;

endpackage

// File: rtl/swdiv_cfg_guard.sv
module swdiv_cfg_guard #(
    parameter int P     = 16,
    parameter int BW    = 9,
    parameter int AW    = 4,
    parameter int RW    = 9,
    parameter int B_MIN = 1,
    parameter int R_MIN = 2,
    parameter int DEF_B = 229,
    parameter int DEF_A = 9,
    parameter int DEF_R = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] cfg_b,
    input  logic [AW-1:0] cfg_a,
    input  logic [RW-1:0] cfg_r,
    input  logic          n_wrap,
    input  logic          r_wrap,
    output logic [BW-1:0] nxt_b,
    output logic [AW-1:0] nxt_a,
    output logic [RW-1:0] nxt_r,
    output logic          cfg_err
);

    localparam logic [BW-1:0] RST_B = BW'(DEF_B);
    localparam logic [AW-1:0] RST_A = AW'(DEF_A);
    localparam logic [RW-1:0] RST_R = RW'(DEF_R);

    logic [BW-1:0] act_b, pend_b;
    logic [AW-1:0] act_a, pend_a;
    logic [RW-1:0] act_r, pend_r;
    logic          pend_n_v, pend_r_v;
    logic          err_q;
    logic          legal;

    // Range rules: swallow count must fit the prescaler and stay below B.
    always_comb begin
        legal = (32'(cfg_b) >= B_MIN)
             && (32'(cfg_a) <  P)
             && (32'(cfg_a) <  32'(cfg_b))
             && (32'(cfg_r) >= R_MIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_b    <= RST_B;
            act_a    <= RST_A;
            act_r    <= RST_R;
            pend_b   <= RST_B;
            pend_a   <= RST_A;
            pend_r   <= RST_R;
            pend_n_v <= 1'b0;
            pend_r_v <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            // Pending values become active only at their own boundary.
            if (n_wrap) begin
                pend_n_v <= 1'b0;
                if (pend_n_v) begin
                    act_b <= pend_b;
                    act_a <= pend_a;
                end
            end
            if (r_wrap) begin
                pend_r_v <= 1'b0;
                if (pend_r_v) begin
                    act_r <= pend_r;
                end
            end
            // A new load wins over the clears above.
            if (load) begin
                err_q <= !legal;
                if (legal) begin
                    pend_b   <= cfg_b;
                    pend_a   <= cfg_a;
                    pend_r   <= cfg_r;
                    pend_n_v <= 1'b1;
                    pend_r_v <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        nxt_b   = pend_n_v ? pend_b : act_b;
        nxt_a   = pend_n_v ? pend_a : act_a;
        nxt_r   = pend_r_v ? pend_r : act_r;
        cfg_err = err_q;
    end

endmodule

// File: rtl/swdiv_frame_fsm.sv
module swdiv_frame_fsm
    import swdiv_pkg::*;
#(
    parameter int P     = 16,
    parameter int BW    = 9,
    parameter int AW    = 4,
    parameter int DEF_B = 229,
    parameter int DEF_A = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] nxt_b,
    input  logic [AW-1:0] nxt_a,
    output logic          frame_end,
    output logic          mod_hi
);

    localparam int            PW     = $clog2(P + 1);
    localparam logic [PW-1:0] PRE_HI = PW'(P);      // P+1 input cycles
    localparam logic [PW-1:0] PRE_LO = PW'(P - 1);  // P input cycles
    localparam logic [BW-1:0] B_ONE  = BW'(1);
    localparam logic [AW-1:0] A_ONE  = AW'(1);
    localparam frame_state_e  ST_RST = (DEF_A != 0) ? ST_SWALLOW : ST_PLAIN;
    localparam logic [PW-1:0] PRE_RST = (DEF_A != 0) ? PRE_HI : PRE_LO;

    frame_state_e  st_q, st_d;
    logic [PW-1:0] pre_q, pre_d;
    logic [BW-1:0] b_q, b_d;
    logic [AW-1:0] a_q, a_d;
    logic          tick, last;

    assign tick = (pre_q == '0);
    assign last = tick && (b_q == B_ONE);

    // Next-state logic.
    always_comb begin
        st_d  = st_q;
        pre_d = pre_q - PW'(1);
        b_d   = b_q;
        a_d   = a_q;
        if (tick) begin
            if (b_q == B_ONE) begin
                // Frame end: reload every counter from the next configuration.
                b_d = nxt_b;
                a_d = nxt_a;
                if (nxt_a != '0) begin
                    st_d  = ST_SWALLOW;
                    pre_d = PRE_HI;
                end else begin
                    st_d  = ST_PLAIN;
                    pre_d = PRE_LO;
                end
            end else begin
                b_d = b_q - B_ONE;
                unique case (st_q)
                    ST_SWALLOW: begin
                        a_d = a_q - A_ONE;
                        if (a_q == A_ONE) begin
                            st_d  = ST_PLAIN;
                            pre_d = PRE_LO;
                        end else begin
                            pre_d = PRE_HI;
                        end
                    end
                    ST_PLAIN: begin
                        pre_d = PRE_LO;
                    end
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RST;
            pre_q <= PRE_RST;
            b_q   <= BW'(DEF_B);
            a_q   <= AW'(DEF_A);
        end else begin
            st_q  <= st_d;
            pre_q <= pre_d;
            b_q   <= b_d;
            a_q   <= a_d;
        end
    end

    // Outputs.
    always_comb begin
        frame_end = last;
        unique case (st_q)
            ST_SWALLOW: mod_hi = 1'b1;
            ST_PLAIN:   mod_hi = 1'b0;
        endcase
    end

endmodule

// File: rtl/swdiv_ref_count.sv
module swdiv_ref_count #(
    parameter int RW    = 9,
    parameter int DEF_R = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] nxt_r,
    output logic          wrap
);

    logic [RW-1:0] cnt_q;

    assign wrap = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RW'(DEF_R - 1);
        end else if (wrap) begin
            cnt_q <= nxt_r - RW'(1);
        end else begin
            cnt_q <= cnt_q - RW'(1);
        end
    end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int P     = 16,
    parameter int BW    = 9,
    parameter int RW    = 9,
    parameter int B_MIN = 1,
    parameter int R_MIN = 2,
    parameter int DEF_B = 229,
    parameter int DEF_A = 9,
    parameter int DEF_R = 160,
    localparam int AW   = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] cfg_b,
    input  logic [AW-1:0] cfg_a,
    input  logic [RW-1:0] cfg_r,
    output logic          n_pulse,
    output logic          r_pulse,
    output logic          mod_hi,
    output logic          cfg_err
);

    logic [BW-1:0] nxt_b;
    logic [AW-1:0] nxt_a;
    logic [RW-1:0] nxt_r;
    logic          n_wrap, r_wrap;

    swdiv_cfg_guard #(
        .P(P), .BW(BW), .AW(AW), .RW(RW), .B_MIN(B_MIN), .R_MIN(R_MIN),
        .DEF_B(DEF_B), .DEF_A(DEF_A), .DEF_R(DEF_R)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_b(cfg_b), .cfg_a(cfg_a), .cfg_r(cfg_r),
        .n_wrap(n_wrap), .r_wrap(r_wrap),
        .nxt_b(nxt_b), .nxt_a(nxt_a), .nxt_r(nxt_r),
        .cfg_err(cfg_err)
    );

    swdiv_frame_fsm #(
        .P(P), .BW(BW), .AW(AW), .DEF_B(DEF_B), .DEF_A(DEF_A)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .nxt_b(nxt_b), .nxt_a(nxt_a),
        .frame_end(n_wrap), .mod_hi(mod_hi)
    );

    swdiv_ref_count #(
        .RW(RW), .DEF_R(DEF_R)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .nxt_r(nxt_r), .wrap(r_wrap)
    );

    assign n_pulse = n_wrap;
    assign r_pulse = r_wrap;

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter int P  = 16,
    parameter int BW = 9
) (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic n_pulse,
    input logic r_pulse,
    input logic mod_hi,
    input logic cfg_err
);

    localparam int GAP_LIM = P * (2 ** BW) + P;

    int gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gap <= 0;
        else if (n_pulse) gap <= 0;
        else              gap <= gap + 1;
    end

    a_r1_n_single: assert property (@(posedge clk) disable iff (!rst_n)
        n_pulse |=> !n_pulse);

    a_r1_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap < GAP_LIM);

    a_r3_r_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_pulse |=> !r_pulse);

    a_r2_end_in_plain: assert property (@(posedge clk) disable iff (!rst_n)
        n_pulse |-> !mod_hi);

    a_r2_rise_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> $past(n_pulse));

    a_r6_err_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

endmodule

bind swallow_divider swallow_divider_chk #(.P(P), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .n_pulse(n_pulse),
    .r_pulse(r_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err)
);

// File: tb/tb_swallow_divider.sv
`timescale 1ns/1ps
module tb_swallow_divider;

    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [8:0] cfg_b = '0;
    logic [3:0] cfg_a = '0;
    logic [8:0] cfg_r = '0;
    logic       n_pulse, r_pulse, mod_hi, cfg_err;

    always #4 clk = ~clk;  // 125 MHz

    swallow_divider dut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_b(cfg_b), .cfg_a(cfg_a), .cfg_r(cfg_r),
        .n_pulse(n_pulse), .r_pulse(r_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err)
    );

    // b, a, r, legal
    localparam int VEC [8][4] = '{
        '{3, 2, 7, 1},
        '{1, 0, 2, 1},
        '{10, 9, 13, 1},
        '{4, 4, 9, 0},
        '{5, 0, 30, 1},
        '{0, 0, 20, 0},
        '{6, 1, 1, 0},
        '{2, 1, 3, 1}
    };

    int tests = 0, fails = 0;
    int cyc = 0, n_prev = 0, r_prev = 0;
    int n_seen = 0, r_seen = 0, n_last = 0, r_last = 0;
    int hi_cnt = 0, hi_last = 0;
    int wide = 0;
    bit n_ev, r_ev, n_q = 0, r_q = 0, done = 0;
    int cur_n, cur_r, cur_a;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        n_ev = 0;
        r_ev = 0;
        if (mod_hi) hi_cnt++;
        if (n_pulse) begin
            n_last = cyc - n_prev; n_prev = cyc; n_seen++; n_ev = 1;
            hi_last = hi_cnt; hi_cnt = 0;
        end
        if (r_pulse) begin
            r_last = cyc - r_prev; r_prev = cyc; r_seen++; r_ev = 1;
        end
        if ((n_pulse && n_q) || (r_pulse && r_q)) wide++;
        n_q = n_pulse;
        r_q = r_pulse;
    endtask

    task automatic run_vec(input int b, input int a, input int r, input int ok);
        int bn, br, new_n, new_r, new_a;
        new_n = ok ? P * b + a : cur_n;
        new_r = ok ? r : cur_r;
        new_a = ok ? a : cur_a;
        bn = n_seen;
        br = r_seen;
        cfg_b = 9'(b); cfg_a = 4'(a); cfg_r = 9'(r); load = 1'b1;
        step();
        load = 1'b0;
        if (ok != 0) chk(cfg_err == 1'b0, "R6 err cleared", int'(cfg_err), 0);
        else         chk(cfg_err == 1'b1, "R5 err set", int'(cfg_err), 1);
        if (n_ev && n_seen == bn + 1) chk(n_last == cur_n, "R7 old frame", n_last, cur_n);
        if (r_ev && r_seen == br + 1) chk(r_last == cur_r, "R8 old ref", r_last, cur_r);
        while (n_seen < bn + 2 || r_seen < br + 2) begin
            step();
            if (n_ev && n_seen == bn + 1) chk(n_last == cur_n, "R7 old frame", n_last, cur_n);
            if (n_ev && n_seen == bn + 2) begin
                chk(n_last == new_n, ok ? "R1 new N" : "R5 N kept", n_last, new_n);
                chk(hi_last == new_a * (P + 1),
                    new_a == 0 ? "R9 no swallow" : "R2 swallow span", hi_last, new_a * (P + 1));
            end
            if (r_ev && r_seen == br + 1) chk(r_last == cur_r, "R8 old ref", r_last, cur_r);
            if (r_ev && r_seen == br + 2)
                chk(r_last == new_r, ok ? "R3 new R" : "R5 R kept", r_last, new_r);
        end
        cur_n = new_n; cur_r = new_r; cur_a = new_a;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        chk(n_pulse == 1'b0, "R4 n_pulse in reset", int'(n_pulse), 0);
        chk(r_pulse == 1'b0, "R4 r_pulse in reset", int'(r_pulse), 0);
        chk(cfg_err == 1'b0, "R4 cfg_err in reset", int'(cfg_err), 0);
        chk(mod_hi == 1'b1, "R4 mod_hi in reset", int'(mod_hi), 1);
        rst_n = 1'b1;
        cyc = 1;
        cur_n = P * 229 + 9;
        cur_r = 160;
        cur_a = 9;
        while (n_seen < 1) begin
            step();
            if (r_ev && r_seen == 1) chk(r_last == 160, "R4 first r_pulse", r_last, 160);
        end
        chk(n_last == 3673, "R4 first n_pulse", n_last, 3673);

        for (int i = 0; i < 8; i++)
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

        // R10: largest legal ratios
        run_vec(511, 15, 511, 1);
        chk(cur_n == 8191, "R10 max N", cur_n, 8191);

        // R1 R3: every pulse seen was one cycle wide
        chk(wide == 0, "R1 R3 pulse width", wide, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule